// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks the operating mode of a small microcontroller core and drives the clock enables that go with each mode. There are four modes: active (main oscillator running, core clocked), subactive (core clocked from the slow subclock), watch (only the timer-A clock path alive on the subclock), and stop (everything halted, subclock optional). Decoded STOP and SBY instruction strobes request entry into a low-power mode. A timer-mode select bit chooses between stop and watch when the request comes from active mode.

Leaving a low-power mode always involves an oscillation-settling wait of `STAB_CYC` main-clock cycles before the core clock is given back. Stop mode is left only through reset or through a stop-cancel input that is held for the whole settling time. Watch mode is left through reset, a timer-A wake request or an external-interrupt wake request. An external-interrupt wake first lines up with the subclock, whose period is `SUB_PERIOD` reference cycles, and then settles. A low-speed select bit, sampled with the wake request, decides whether the core resumes in active or in subactive mode.

Top module: `lpm_sequencer`

## Requirements
- R1: In active mode (mode code 2'b00), a `stop_op` pulse with `tmr_sel`=0 enters stop mode (code 2'b11), with `main_osc_en`, `cpu_clk_en` and `tmra_clk_en` all 0.
- R2: In active mode, a `stop_op` pulse with `tmr_sel`=1 enters watch mode (code 2'b10).
- R3: In subactive mode (code 2'b01), either a `stop_op` or an `sby_op` pulse enters watch mode; an `sby_op` pulse in active mode leaves the mode at active.
- R4: In stop mode, `sub_osc_en` is the inverse of `subosc_off_sel`, one clock after that input changes.
- R5: In watch mode with no wait in progress, `main_osc_en`=0, `sub_osc_en`=1, `cpu_clk_en`=0 and `tmra_clk_en`=1.
- R6: Stop mode is left, to active mode, only when `stop_cancel` is sampled high on `STAB_CYC` consecutive edges; a shorter pulse leaves the mode at stop, and wake requests have no effect in stop mode. While `stop_cancel` is high in stop mode, `main_osc_en`=1.
- R7: Watch mode is left only on `tmra_wake` or `ext_wake`; `stop_cancel` has no effect in watch mode.
- R8: The mode after a wake from watch is active when `lowspd_sel` is 0 and subactive when it is 1, sampled on the edge that samples the wake request.
- R9: After a `tmra_wake`, `cpu_clk_en` rises on exactly the (`STAB_CYC`+1)th clock edge, counting the edge that samples the request as the first.
- R10: After an `ext_wake`, `cpu_clk_en` rises on an edge numbered between `SUB_PERIOD`+`STAB_CYC`+2 and 2*`SUB_PERIOD`+`STAB_CYC`+1, counting the same way.
- R11: An edge with `rst` high sets mode active, `main_osc_en`=1, `sub_osc_en`=1, `cpu_clk_en`=0, `tmra_clk_en`=0 and `stab_busy`=0; the first edge with `rst` low sets `cpu_clk_en`=1.
- R12: `mode` carries the code 00 active, 01 subactive, 10 watch, 11 stop; `stab_busy` is 1 during a settling wait and only while the code is watch or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_op | input | 1 | Decoded STOP instruction strobe |
| sby_op | input | 1 | Decoded SBY instruction strobe |
| tmr_sel | input | 1 | Timer-mode select: 0 stop, 1 watch |
| lowspd_sel | input | 1 | Resume target after a wake: 0 active, 1 subactive |
| subosc_off_sel | input | 1 | 1 turns the subclock oscillator off in stop mode |
| stop_cancel | input | 1 | Stop-cancel request, level sensitive |
| tmra_wake | input | 1 | Timer-A wake request |
| ext_wake | input | 1 | External-interrupt wake request |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subclock oscillator enable |
| cpu_clk_en | output | 1 | Internal (core) clock gate |
| tmra_clk_en | output | 1 | Timer-A clock path enable |
| mode | output | 2 | Current mode code |
| stab_busy | output | 1 | Settling wait in progress |

## Verification
The bench walks through every entry and exit edge of the mode graph, both by directed sequences and by random sequences from a fixed seed. Stop-cancel pulses one cycle short of the settling time are set against pulses of exactly that length and longer, which pins the hold counter to its exact limit. Timer wakes are measured to the exact edge. External wakes, which land at random subclock phases, must fall inside the alignment window, so that a missing or doubled subclock alignment is told apart from a correct one. Each wake is repeated with both low-speed settings to separate the two resume targets.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_ACT   = 2'b00,
    MODE_SUB   = 2'b01,
    MODE_WATCH = 2'b10,
    MODE_STOP  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_ACT,
    ST_SUB,
    ST_WATCH,
    ST_STOP,
    ST_WSYNC,   // external wake: aligning to subclock
    ST_WSTAB    // settling count before clock restore
  } state_e;

  typedef struct packed {
    logic  main_en;
    logic  sub_en;
    logic  cpu_en;
    logic  tmra_en;
    logic  busy;
    mode_e mode;
  } outs_t;

  function automatic outs_t decode_outs(state_e st, logic cancel,
                                        logic tgt_act, logic sub_off);
    outs_t o;
    o.main_en = 1'b0;
    o.sub_en  = 1'b1;
    o.cpu_en  = 1'b0;
    o.tmra_en = 1'b0;
    o.busy    = 1'b0;
    o.mode    = MODE_ACT;
    case (st)
      ST_SUB: begin
        o.cpu_en  = 1'b1;
        o.tmra_en = 1'b1;
        o.mode    = MODE_SUB;
      end
      ST_WATCH: begin
        o.tmra_en = 1'b1;
        o.mode    = MODE_WATCH;
      end
      ST_WSYNC, ST_WSTAB: begin
        o.tmra_en = 1'b1;
        o.main_en = tgt_act;
        o.busy    = 1'b1;
        o.mode    = MODE_WATCH;
      end
      ST_STOP: begin
        o.sub_en  = ~sub_off;
        o.main_en = cancel;
        o.busy    = cancel;
        o.mode    = MODE_STOP;
      end
      default: begin
        o.main_en = 1'b1;
        o.cpu_en  = 1'b1;
        o.tmra_en = 1'b1;
        o.mode    = MODE_ACT;
      end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lpm_subtick.sv
module lpm_subtick #(
  parameter int PERIOD = 32
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || phase_q == LAST) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);
endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] END_VAL = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == END_VAL);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stop_op,
  input  logic   sby_op,
  input  logic   tmr_sel,
  input  logic   lowspd_sel,
  input  logic   stop_cancel,
  input  logic   tmra_wake,
  input  logic   ext_wake,
  input  logic   sub_tick,
  input  logic   stab_last,
  output logic   stab_run,
  output state_e state_d,
  output logic   tgt_d
);
  state_e state_q;
  logic   tgt_q;
  logic   seen_q, seen_d;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    seen_d  = seen_q;
    case (state_q)
      ST_ACT: begin
        if (stop_op) state_d = tmr_sel ? ST_WATCH : ST_STOP;
      end
      ST_SUB: begin
        if (stop_op || sby_op) state_d = ST_WATCH;
      end
      ST_WATCH: begin
        if (tmra_wake) begin
          state_d = ST_WSTAB;
          tgt_d   = ~lowspd_sel;
        end else if (ext_wake) begin
          state_d = ST_WSYNC;
          tgt_d   = ~lowspd_sel;
          seen_d  = 1'b0;
        end
      end
      ST_WSYNC: begin
        if (sub_tick) begin
          if (seen_q) state_d = ST_WSTAB;
          seen_d = 1'b1;
        end
      end
      ST_WSTAB: begin
        if (stab_last) state_d = tgt_q ? ST_ACT : ST_SUB;
      end
      ST_STOP: begin
        if (stab_last) state_d = ST_ACT;
      end
      default: state_d = ST_ACT;
    endcase
  end

  assign stab_run = (state_q == ST_WSTAB) || (state_q == ST_STOP && stop_cancel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACT;
      tgt_q   <= 1'b1;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      seen_q  <= seen_d;
    end
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int STAB_CYC   = 16,
  parameter int SUB_PERIOD = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_op,
  input  logic       sby_op,
  input  logic       tmr_sel,
  input  logic       lowspd_sel,
  input  logic       subosc_off_sel,
  input  logic       stop_cancel,
  input  logic       tmra_wake,
  input  logic       ext_wake,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic       cpu_clk_en,
  output logic       tmra_clk_en,
  output logic [1:0] mode,
  output logic       stab_busy
);
  logic   sub_tick, stab_run, stab_last, tgt_d;
  state_e state_d;
  outs_t  outs_q;

  lpm_subtick #(.PERIOD(SUB_PERIOD)) u_subtick (
    .clk (clk),
    .rst (rst),
    .tick(sub_tick)
  );

  lpm_stab_timer #(.LIMIT(STAB_CYC)) u_stab (
    .clk (clk),
    .rst (rst),
    .run (stab_run),
    .last(stab_last)
  );

  lpm_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stop_op    (stop_op),
    .sby_op     (sby_op),
    .tmr_sel    (tmr_sel),
    .lowspd_sel (lowspd_sel),
    .stop_cancel(stop_cancel),
    .tmra_wake  (tmra_wake),
    .ext_wake   (ext_wake),
    .sub_tick   (sub_tick),
    .stab_last  (stab_last),
    .stab_run   (stab_run),
    .state_d    (state_d),
    .tgt_d      (tgt_d)
  );

  // Outputs registered from the next state so they line up with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      outs_q.main_en <= 1'b1;
      outs_q.sub_en  <= 1'b1;
      outs_q.cpu_en  <= 1'b0;
      outs_q.tmra_en <= 1'b0;
      outs_q.busy    <= 1'b0;
      outs_q.mode    <= MODE_ACT;
    end else begin
      outs_q <= decode_outs(state_d, stop_cancel, tgt_d, subosc_off_sel);
    end
  end

  assign main_osc_en = outs_q.main_en;
  assign sub_osc_en  = outs_q.sub_en;
  assign cpu_clk_en  = outs_q.cpu_en;
  assign tmra_clk_en = outs_q.tmra_en;
  assign mode        = outs_q.mode;
  assign stab_busy   = outs_q.busy;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_cancel,
  input logic       main_osc_en,
  input logic       sub_osc_en,
  input logic       cpu_clk_en,
  input logic       tmra_clk_en,
  input logic [1:0] mode,
  input logic       stab_busy
);
  // R1: stop mode keeps core and timer clocks off
  p_stop_clocks_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |-> (!cpu_clk_en && !tmra_clk_en));

  // R5: settled watch mode enables only the timer path on the subclock
  p_watch_clocks_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !stab_busy) |-> (!main_osc_en && sub_osc_en && !cpu_clk_en && tmra_clk_en));

  // R6: without stop-cancel, stop mode persists
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !stop_cancel) |=> (mode == 2'b11));

  // R11: reset forces active with main oscillator on and core clock gated
  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> (mode == 2'b00 && main_osc_en && !cpu_clk_en && !stab_busy));

  // R12: settling flag only in watch or stop codes
  p_busy_code_r12: assert property (@(posedge clk) disable iff (rst)
    stab_busy |-> mode[1]);
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .stop_cancel(stop_cancel),
  .main_osc_en(main_osc_en),
  .sub_osc_en (sub_osc_en),
  .cpu_clk_en (cpu_clk_en),
  .tmra_clk_en(tmra_clk_en),
  .mode       (mode),
  .stab_busy  (stab_busy)
);

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;   // settling count
  localparam int P = 6;   // subclock period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_op = 0, sby_op = 0, tmr_sel = 0, lowspd_sel = 0, subosc_off_sel = 0;
  logic stop_cancel = 0, tmra_wake = 0, ext_wake = 0;
  logic main_osc_en, sub_osc_en, cpu_clk_en, tmra_clk_en, stab_busy;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_sequencer #(.STAB_CYC(N), .SUB_PERIOD(P)) u_lpm_sequencer (
    .clk(clk), .rst(rst), .stop_op(stop_op), .sby_op(sby_op), .tmr_sel(tmr_sel),
    .lowspd_sel(lowspd_sel), .subosc_off_sel(subosc_off_sel), .stop_cancel(stop_cancel),
    .tmra_wake(tmra_wake), .ext_wake(ext_wake), .main_osc_en(main_osc_en),
    .sub_osc_en(sub_osc_en), .cpu_clk_en(cpu_clk_en), .tmra_clk_en(tmra_clk_en),
    .mode(mode), .stab_busy(stab_busy)
  );

  function automatic logic [1:0] exp_resume(input bit ls);
    return ls ? 2'b01 : 2'b00;
  endfunction
  function automatic int lat_lo(input bit ext);
    return ext ? (P + N + 2) : (N + 1);
  endfunction
  function automatic int lat_hi(input bit ext);
    return ext ? (2*P + N + 1) : (N + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_op(input bit is_stop, input bit tsel);
    tmr_sel = tsel;
    if (is_stop) stop_op = 1; else sby_op = 1;
    tick(1);
    stop_op = 0; sby_op = 0;
  endtask

  task automatic hold_cancel(input int len);
    stop_cancel = 1;
    tick(len);
    stop_cancel = 0;
    tick(1);
  endtask

  task automatic wake(input bit ext, input bit ls, output int cyc);
    lowspd_sel = ls;
    if (ext) ext_wake = 1; else tmra_wake = 1;
    cyc = 0;
    do begin
      tick(1);
      ext_wake = 0; tmra_wake = 0;
      cyc++;
    end while (!cpu_clk_en && cyc < 1000);
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    void'($urandom(32'd20417));
    tick(3);
    // R11 reset state
    chk("R11 mode in reset", mode, 0);
    chk("R11 main osc in reset", main_osc_en, 1);
    chk("R11 cpu clk gated in reset", cpu_clk_en, 0);
    chk("R11 busy in reset", stab_busy, 0);
    rst = 0;
    tick(1);
    chk("R11 cpu clk after reset release", cpu_clk_en, 1);
    chk("R12 active code", mode, 0);

    // R3: SBY in active is ignored
    pulse_op(0, 0);
    tick(1);
    chk("R3 sby in active ignored", mode, 0);

    // R1 stop entry
    subosc_off_sel = 0;
    pulse_op(1, 0);
    chk("R1 stop code", mode, 3);
    chk("R1 main off", main_osc_en, 0);
    chk("R1 cpu off", cpu_clk_en, 0);
    chk("R1 tmra off", tmra_clk_en, 0);
    chk("R4 sub osc on when select 0", sub_osc_en, 1);
    subosc_off_sel = 1;
    tick(1);
    chk("R4 sub osc off when select 1", sub_osc_en, 0);
    subosc_off_sel = 0;

    // R6: wakes ignored in stop, short cancel rejected
    tmra_wake = 1; ext_wake = 1;
    tick(1);
    tmra_wake = 0; ext_wake = 0;
    tick(2 * N + 2 * P);
    chk("R6 wake requests ignored in stop", mode, 3);
    stop_cancel = 1;
    tick(1);
    chk("R6 main osc on during cancel hold", main_osc_en, 1);
    chk("R12 busy during cancel hold", stab_busy, 1);
    tick(N - 2);
    stop_cancel = 0;
    tick(1);
    chk("R6 short cancel stays stop", mode, 3);
    chk("R6 main osc off after short cancel", main_osc_en, 0);
    hold_cancel(N);
    chk("R6 full cancel exits to active", mode, 0);
    chk("R6 cpu on after cancel", cpu_clk_en, 1);

    // R2 / R5 watch entry from active
    pulse_op(1, 1);
    chk("R2 watch code", mode, 2);
    chk("R5 watch main off", main_osc_en, 0);
    chk("R5 watch sub on", sub_osc_en, 1);
    chk("R5 watch cpu off", cpu_clk_en, 0);
    chk("R5 watch tmra on", tmra_clk_en, 1);
    hold_cancel(N + 3);
    chk("R7 stop_cancel ignored in watch", mode, 2);

    // R9 timer wake to active
    wake(0, 0, c);
    chk("R9 timer wake latency", c, N + 1);
    chk("R8 resume active", mode, 0);

    // R10 external wake to subactive
    pulse_op(1, 1);
    wake(1, 1, c);
    chk_range("R10 external wake latency", c, lat_lo(1), lat_hi(1));
    chk("R8 resume subactive", mode, 1);
    chk("R8 subactive main off", main_osc_en, 0);

    // R3 subactive to watch via SBY then STOP
    pulse_op(0, 0);
    chk("R3 sby in subactive enters watch", mode, 2);
    wake(0, 1, c);
    chk("R8 timer wake to subactive", mode, 1);
    pulse_op(1, 0);
    chk("R3 stop in subactive enters watch", mode, 2);
    wake(1, 0, c);
    chk_range("R10 external wake to active latency", c, lat_lo(1), lat_hi(1));
    chk("R8 external wake to active", mode, 0);

    // Random sequences
    for (int i = 0; i < 40; i++) begin
      int r;
      bit ls, ext;
      r = $urandom;
      tick(r[7:4] % 5);
      if (r[0]) begin
        subosc_off_sel = r[1];
        pulse_op(1, 0);
        chk("R1 random stop entry", mode, 3);
        chk("R4 random sub osc", sub_osc_en, !r[1]);
        hold_cancel(1 + (r[11:8] % (N - 1)));
        chk("R6 random short cancel", mode, 3);
        hold_cancel(N + (r[13:12] % 3));
        chk("R6 random full cancel", mode, 0);
        subosc_off_sel = 0;
      end else begin
        ls = r[2];
        ext = r[3];
        pulse_op(1, 1);
        chk("R2 random watch entry", mode, 2);
        wake(ext, ls, c);
        chk_range(ext ? "R10 random latency" : "R9 random latency", c, lat_lo(ext), lat_hi(ext));
        chk("R8 random resume", mode, exp_resume(ls));
        if (ls) begin
          pulse_op(r[14], 0);
          chk("R3 random subactive to watch", mode, 2);
          wake(0, 0, c);
          chk("R9 random return latency", c, N + 1);
          chk("R8 random return active", mode, 0);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule